// File: doc/BRIEF.md
# Dual-Channel Parallel Port Adapter

This block gives a processor two independent 8-bit parallel ports behind four register locations. Each channel has an output register, a per-bit direction register, a control register and two handshake lines (C1 and C2). The lines are synchronized and edge-detected. The active edge is programmable, and it sets a flag in the control register. An enabled flag drives the channel's active-high interrupt output.

The processor side is a synchronous bus with a 2-bit address, write data, and read and write strobes. Read data is combinational while the read strobe is high. Any side effect of a read, such as clearing flags, takes effect at the clock edge that ends the read cycle. Software reads the data location to collect a port value. That read also acknowledges the channel's pending handshake events.

Top module: `pia_dual_port`

## Requirements
- R1: After reset, each channel's output, direction and control registers are all zero. Every pin is an input, and both interrupt outputs are low.
- R2: Address bit 1 selects the channel (0 = A, 1 = B). Address bit 0 selects the control register (1) or the data/direction location (0).
- R3: Control bit 2 routes the data/direction location to the output register when it is 1, and to the direction register when it is 0. This applies to both reads and writes.
- R4: A read of the output register returns, bit by bit, the input pin where the direction bit is 0 and the output register where it is 1.
- R5: A control write loads bits 5..0 only. Bits 7..6 read back as flags. A write with bit 5 set also clears bit 6.
- R6: Control bit 1 selects the C1 active edge (1 = rising, 0 = falling). After a two-flop synchronizer, the active edge sets bit 7, three clock edges after the pin changes. The other edge has no effect.
- R7: The interrupt output is high while (bit 7 and bit 0) or (bit 6 and bit 3) is true. It stays high until the flag is cleared.
- R8: Control bit 4 selects the C2 active edge (1 = rising). That edge sets bit 6.
- R9: While control bit 5 is 1, C2 is an output (the C2 output-enable pin is high), and C2 edges do not set bit 6.
- R10: A read of the output register clears bits 7..6 and drops the interrupt. A read of the direction register or the control register clears nothing.
- R11: When an active edge and a flag-clearing data read fall in the same cycle, the flag is set and the interrupt stays asserted.
- R12: The channels are independent. An access or an event on one channel leaves the other channel's registers, pins and interrupt unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| rdata | output | 8 | Read data |
| pa_in | input | 8 | Channel A input pins |
| pa_out | output | 8 | Channel A output register |
| pa_dir | output | 8 | Channel A direction (1 = output) |
| pa_c1 | input | 1 | Channel A C1 line |
| pa_c2 | input | 1 | Channel A C2 line |
| pa_c2_oe | output | 1 | Channel A C2 marked as output |
| pa_irq | output | 1 | Channel A interrupt |
| pb_in | input | 8 | Channel B input pins |
| pb_out | output | 8 | Channel B output register |
| pb_dir | output | 8 | Channel B direction (1 = output) |
| pb_c1 | input | 1 | Channel B C1 line |
| pb_c2 | input | 1 | Channel B C2 line |
| pb_c2_oe | output | 1 | Channel B C2 marked as output |
| pb_irq | output | 1 | Channel B interrupt |

## Verification
Two functions can fall in the same cycle: a synchronized active C1 edge setting a flag, and a data read clearing the same flag. The bench provokes the collision by raising C1 and then timing a data read so that its closing clock edge is the third edge after the pin change. That is the edge on which the synchronizer delivers the event. The bench then reads the control register and the interrupt output. It passes the result only if the flag and the interrupt survived, so the event is not lost.

// File: rtl/pia_pkg.sv
package pia_pkg;

    localparam int CTL_W = 8;

    // control register field positions
    localparam int CB_C1_IE   = 0;
    localparam int CB_C1_RISE = 1;
    localparam int CB_SEL_OUT = 2;
    localparam int CB_C2_IE   = 3;
    localparam int CB_C2_RISE = 4;
    localparam int CB_C2_OUT  = 5;
    localparam int CB_FLAG2   = 6;
    localparam int CB_FLAG1   = 7;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_t;

    function automatic logic pick_edge(input edge_t ev, input logic rising);
        return rising ? ev.rise : ev.fall;
    endfunction

endpackage

// File: rtl/pia_edge_sync.sv
module pia_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           pin,
    output pia_pkg::edge_t ev
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], pin};
    end

    assign ev.rise =  sh[STAGES-1] & ~sh[STAGES];
    assign ev.fall = ~sh[STAGES-1] &  sh[STAGES];
endmodule

// File: rtl/pia_channel.sv
module pia_channel
    import pia_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel,
    input  logic              reg_ctl,
    input  logic              rd,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] pins_in,
    input  edge_t             c1_ev,
    input  edge_t             c2_ev,
    output logic [DATA_W-1:0] rdata,
    output logic [DATA_W-1:0] out_q,
    output logic [DATA_W-1:0] ddr_q,
    output logic [CTL_W-1:0]  ctl_q,
    output logic              irq,
    output logic              c2_oe
);
    logic data_rd, data_wr, ctl_wr, c1_hit, c2_hit;
    logic [1:0] flag_nxt;

    assign data_rd = sel & rd & ~reg_ctl & ctl_q[CB_SEL_OUT];
    assign data_wr = sel & wr & ~reg_ctl;
    assign ctl_wr  = sel & wr &  reg_ctl;
    assign c1_hit  = pick_edge(c1_ev, ctl_q[CB_C1_RISE]);
    assign c2_hit  = pick_edge(c2_ev, ctl_q[CB_C2_RISE]) & ~ctl_q[CB_C2_OUT];

    always_comb begin
        flag_nxt = {ctl_q[CB_FLAG1], ctl_q[CB_FLAG2]};
        if (data_rd) flag_nxt = 2'b00;
        if (ctl_wr && wdata[CB_C2_OUT]) flag_nxt[0] = 1'b0;
        if (c1_hit) flag_nxt[1] = 1'b1;
        if (c2_hit) flag_nxt[0] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
            ddr_q <= '0;
            ctl_q <= '0;
        end else begin
            if (data_wr) begin
                if (ctl_q[CB_SEL_OUT]) out_q <= wdata;
                else                   ddr_q <= wdata;
            end
            if (ctl_wr) ctl_q[CB_C2_OUT:0] <= wdata[CB_C2_OUT:0];
            ctl_q[CB_FLAG1:CB_FLAG2] <= flag_nxt;
        end
    end

    always_comb begin
        if (reg_ctl)
            rdata = DATA_W'(ctl_q);
        else if (ctl_q[CB_SEL_OUT])
            rdata = (pins_in & ~ddr_q) | (out_q & ddr_q);
        else
            rdata = ddr_q;
    end

    assign irq   = (ctl_q[CB_FLAG1] & ctl_q[CB_C1_IE]) | (ctl_q[CB_FLAG2] & ctl_q[CB_C2_IE]);
    assign c2_oe = ctl_q[CB_C2_OUT];
endmodule

// File: rtl/pia_dual_port.sv
module pia_dual_port
    import pia_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              wr,
    input  logic              rd,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] pa_in,
    output logic [DATA_W-1:0] pa_out,
    output logic [DATA_W-1:0] pa_dir,
    input  logic              pa_c1,
    input  logic              pa_c2,
    output logic              pa_c2_oe,
    output logic              pa_irq,
    input  logic [DATA_W-1:0] pb_in,
    output logic [DATA_W-1:0] pb_out,
    output logic [DATA_W-1:0] pb_dir,
    input  logic              pb_c1,
    input  logic              pb_c2,
    output logic              pb_c2_oe,
    output logic              pb_irq
);
    localparam int NCH = 2;

    logic [NCH-1:0][DATA_W-1:0] pins, outs, ddrs, rds;
    logic [NCH-1:0][CTL_W-1:0]  ctl_q;
    logic [NCH-1:0]             c1_pin, c2_pin, irqs, oes;
    edge_t [NCH-1:0]            c1_ev, c2_ev;

    assign pins   = {pb_in, pa_in};
    assign c1_pin = {pb_c1, pa_c1};
    assign c2_pin = {pb_c2, pa_c2};

    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        pia_edge_sync #(.STAGES(SYNC_STAGES)) u_s1 (
            .clk(clk), .rst(rst), .pin(c1_pin[ch]), .ev(c1_ev[ch]));
        pia_edge_sync #(.STAGES(SYNC_STAGES)) u_s2 (
            .clk(clk), .rst(rst), .pin(c2_pin[ch]), .ev(c2_ev[ch]));
        pia_channel #(.DATA_W(DATA_W)) u_chan (
            .clk(clk), .rst(rst),
            .sel(addr[1] == 1'(ch)), .reg_ctl(addr[0]),
            .rd(rd), .wr(wr), .wdata(wdata), .pins_in(pins[ch]),
            .c1_ev(c1_ev[ch]), .c2_ev(c2_ev[ch]),
            .rdata(rds[ch]), .out_q(outs[ch]), .ddr_q(ddrs[ch]),
            .ctl_q(ctl_q[ch]), .irq(irqs[ch]), .c2_oe(oes[ch]));
    end

    assign rdata    = rds[addr[1]];
    assign pa_out   = outs[0];
    assign pb_out   = outs[1];
    assign pa_dir   = ddrs[0];
    assign pb_dir   = ddrs[1];
    assign pa_irq   = irqs[0];
    assign pb_irq   = irqs[1];
    assign pa_c2_oe = oes[0];
    assign pb_c2_oe = oes[1];
endmodule

// File: rtl/pia_dual_port_chk.sv
module pia_dual_port_chk
    import pia_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rd,
    input logic              wr,
    input logic [1:0]        addr,
    input logic [DATA_W-1:0] wdata,
    input logic [CTL_W-1:0]  ctl_a,
    input logic [CTL_W-1:0]  ctl_b,
    input logic              irq_a,
    input edge_t             c1_ev_a,
    input edge_t             c2_ev_a
);
    logic rd_data_a, wctl_a, c1_act, c2_act, c2_any;

    assign rd_data_a = rd && addr == 2'b00 && ctl_a[CB_SEL_OUT];
    assign wctl_a    = wr && addr == 2'b01;
    assign c1_act    = ctl_a[CB_C1_RISE] ? c1_ev_a.rise : c1_ev_a.fall;
    assign c2_act    = (ctl_a[CB_C2_RISE] ? c2_ev_a.rise : c2_ev_a.fall) && !ctl_a[CB_C2_OUT];
    assign c2_any    = c2_ev_a.rise || c2_ev_a.fall;

    AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (ctl_a == '0 && ctl_b == '0 && !irq_a)); // R1
    AST_CTL_LOAD: assert property (@(posedge clk) disable iff (rst)
        wctl_a |=> ctl_a[5:0] == $past(wdata[5:0])); // R5
    AST_C1_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
        c1_act |=> ctl_a[CB_FLAG1]); // R6
    AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_a) |-> $past(c1_act || c2_act || wctl_a)); // R7
    AST_C2_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ctl_a[CB_C2_OUT] && c2_any && !rd_data_a && !wctl_a) |=> $stable(ctl_a[CB_FLAG2])); // R9
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (rd_data_a && !c1_act && !c2_act && !wr) |=> (ctl_a[7:6] == 2'b00 && !irq_a)); // R10
    AST_EDGE_WINS: assert property (@(posedge clk) disable iff (rst)
        (rd_data_a && c1_act) |=> ctl_a[CB_FLAG1]); // R11
endmodule

bind pia_dual_port pia_dual_port_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst(rst), .rd(rd), .wr(wr), .addr(addr), .wdata(wdata),
    .ctl_a(ctl_q[0]), .ctl_b(ctl_q[1]), .irq_a(pa_irq),
    .c1_ev_a(c1_ev[0]), .c2_ev_a(c2_ev[0]));

// File: tb/pia_dual_port_bench.sv
module pia_dual_port_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] rdata, pa_in = '0, pb_in = '0, pa_out, pa_dir, pb_out, pb_dir;
    logic       pa_c1 = 0, pa_c2 = 0, pb_c1 = 0, pb_c2 = 0;
    logic       pa_c2_oe, pb_c2_oe, pa_irq, pb_irq;
    int         n_chk = 0, n_fail = 0;
    logic [7:0] v;

    always #5 clk = ~clk;

    pia_dual_port u_pia_dual_port (
        .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr(wr), .rd(rd),
        .rdata(rdata), .pa_in(pa_in), .pa_out(pa_out), .pa_dir(pa_dir),
        .pa_c1(pa_c1), .pa_c2(pa_c2), .pa_c2_oe(pa_c2_oe), .pa_irq(pa_irq),
        .pb_in(pb_in), .pb_out(pb_out), .pb_dir(pb_dir), .pb_c1(pb_c1),
        .pb_c2(pb_c2), .pb_c2_oe(pb_c2_oe), .pb_irq(pb_irq));

    task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %02h expected %02h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1'b1;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1'b1;
        #1 d = rdata;
        @(negedge clk); rd = 1'b0;
    endtask

    task automatic t_reset;
        bus_rd(2'b01, v); chk("R1 ctrl A", v, 8'h00);
        bus_rd(2'b11, v); chk("R1 ctrl B", v, 8'h00);
        chk("R1 pins", {pa_out | pa_dir | pb_out | pb_dir}, 8'h00);
        chk("R1 irq", {6'b0, pa_irq, pb_irq}, 8'h00);
    endtask

    task automatic t_regs;
        bus_wr(2'b00, 8'hF0);
        bus_wr(2'b01, 8'h04);
        bus_wr(2'b00, 8'hA5);
        chk("R3 dir A", pa_dir, 8'hF0);
        chk("R3 out A", pa_out, 8'hA5);
        pa_in = 8'h3C;
        bus_rd(2'b00, v); chk("R4 mixed read", v, 8'hAC);
        pa_in = 8'hC3;
        bus_rd(2'b00, v); chk("R4 mixed read 2", v, 8'hA3);
        bus_wr(2'b01, 8'h00);
        bus_rd(2'b00, v); chk("R3 dir readback", v, 8'hF0);
        chk("R12 B untouched", pb_out | pb_dir, 8'h00);
        bus_wr(2'b11, 8'h04);
        bus_wr(2'b10, 8'h5A);
        chk("R2 out B", pb_out, 8'h5A);
        chk("R2 out A kept", pa_out, 8'hA5);
        bus_wr(2'b11, 8'h00);
    endtask

    task automatic t_ctrl;
        bus_wr(2'b01, 8'hFF);
        bus_rd(2'b01, v); chk("R5 flags not writable", v, 8'h3F);
        chk("R9 c2 oe", {7'b0, pa_c2_oe}, 8'h01);
        bus_wr(2'b01, 8'h04);
    endtask

    task automatic t_c1;
        bus_wr(2'b01, 8'h07);
        pa_c1 = 1'b1; cyc(4);
        bus_rd(2'b01, v); chk("R6 rising sets flag", v, 8'h87);
        chk("R7 irq raised", {7'b0, pa_irq}, 8'h01);
        bus_rd(2'b01, v); chk("R10 ctrl read keeps irq", {7'b0, pa_irq}, 8'h01);
        bus_rd(2'b00, v);
        bus_rd(2'b01, v); chk("R10 data read clears", v, 8'h07);
        chk("R10 irq dropped", {7'b0, pa_irq}, 8'h00);
        pa_c1 = 1'b0; cyc(4);
        bus_rd(2'b01, v); chk("R6 wrong edge ignored", v, 8'h07);
        bus_wr(2'b01, 8'h05);
        pa_c1 = 1'b1; cyc(4);
        bus_rd(2'b01, v); chk("R6 rise ignored in fall mode", v, 8'h05);
        pa_c1 = 1'b0; cyc(4);
        bus_rd(2'b01, v); chk("R6 falling sets flag", v, 8'h85);
        bus_rd(2'b00, v);
        bus_wr(2'b01, 8'h06);
        pa_c1 = 1'b1; cyc(4);
        bus_rd(2'b01, v); chk("R7 flag without enable", v, 8'h86);
        chk("R7 irq masked", {7'b0, pa_irq}, 8'h00);
        bus_rd(2'b00, v);
        bus_wr(2'b01, 8'h03);
        pa_c1 = 1'b0; cyc(4);
        pa_c1 = 1'b1; cyc(4);
        bus_rd(2'b00, v);
        chk("R10 dir read keeps irq", {7'b0, pa_irq}, 8'h01);
        bus_wr(2'b01, 8'h07);
        bus_rd(2'b00, v);
        chk("R10 cleared after select", {7'b0, pa_irq}, 8'h00);
        pa_c1 = 1'b0; cyc(4);
    endtask

    task automatic t_c2;
        bus_wr(2'b01, 8'h1C);
        pa_c2 = 1'b1; cyc(4);
        bus_rd(2'b01, v); chk("R8 c2 rising flag", v, 8'h5C);
        chk("R8 c2 irq", {7'b0, pa_irq}, 8'h01);
        bus_rd(2'b00, v);
        bus_wr(2'b01, 8'h3C);
        pa_c2 = 1'b0; cyc(4);
        pa_c2 = 1'b1; cyc(4);
        bus_rd(2'b01, v); chk("R9 output mode ignores edges", v, 8'h3C);
        chk("R9 no irq", {7'b0, pa_irq}, 8'h00);
        bus_wr(2'b01, 8'h0C);
        pa_c2 = 1'b0; cyc(4);
        bus_rd(2'b01, v); chk("R8 c2 falling flag", v, 8'h4C);
        bus_wr(2'b01, 8'h2C);
        bus_rd(2'b01, v); chk("R5 bit5 write clears bit6", v, 8'h2C);
        chk("R5 irq gone", {7'b0, pa_irq}, 8'h00);
        bus_wr(2'b01, 8'h04);
    endtask

    task automatic t_race;
        bus_wr(2'b01, 8'h07);
        pa_c1 = 1'b1;
        @(negedge clk);
        bus_rd(2'b00, v);
        bus_rd(2'b01, v); chk("R11 edge wins over clear", v, 8'h87);
        chk("R11 irq held", {7'b0, pa_irq}, 8'h01);
        bus_rd(2'b00, v);
        pa_c1 = 1'b0; cyc(4);
    endtask

    task automatic t_chan_b;
        bus_wr(2'b11, 8'h07);
        pb_c1 = 1'b1; cyc(4);
        chk("R12 irq B", {6'b0, pa_irq, pb_irq}, 8'h01);
        bus_rd(2'b01, v); chk("R12 ctrl A unaffected", v, 8'h07);
        bus_rd(2'b10, v);
        chk("R12 irq B cleared", {7'b0, pb_irq}, 8'h00);
    endtask

    initial begin
        cyc(3);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_ctrl();
        t_c1();
        t_c2();
        t_race();
        t_chan_b();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule